// File: doc/BRIEF.md
# Source-Routed Router Input Controller

This block is one input port of a five-port tile router whose ports face north, east, south, west and the local tile. Flits arrive with a 2-bit kind, a virtual-channel number, a 16-bit route field and a data word. Each virtual channel has its own small FIFO and its own ready bit back to the sender. The output port is not looked up from a destination address. Every packet carries its own route as a list of 2-bit turn codes. The controller takes the lowest code, turns it into an absolute output, and forwards the head flit with the route shifted down one hop. The next router therefore finds its own turn code in the lowest bits.

When a head flit reaches the front of its channel FIFO, the turn code is decoded against the direction the packet is travelling. The output chosen this way is held for that channel until the tail flit has been granted. Several channels may hold outputs at the same time. One flit per cycle is offered to the output side through a one-hot request and a single grant. A flit that has been offered and not yet granted stays on the outputs unchanged. The controller is instantiated five times per router, with a parameter that gives the side it serves.

Top module: `srcroute_in_ctrl`

## Requirements
- R1: After reset `out_req` is zero, `route_err` is zero, `out_kind` is idle (00) and every bit of `up_ready` is one.
- R2: On a non-local input (PORT_ID 0..3 = N, E, S, W), the travelling heading is the opposite side. Hop code 00 (straight) selects the heading. Code 01 (left) selects heading+3 mod 4. Code 10 (right) selects heading+1 mod 4. Code 11 selects the local output 4. `out_req` bit d is set for output d. The input never requests its own arrival side.
- R3: On the local input (PORT_ID 4), the heading is the parameter LOCAL_HEAD. Left, right and extract decode as in R2, and code 00 is a routing error. The local input never requests the LOCAL_HEAD output.
- R4: A head flit (kind 01) leaves with its route shifted right by two bits, and the top two bits are zero. Body (10) and tail (11) flits leave with their route unchanged.
- R5: The output chosen on the head flit is requested for every later flit of that channel, whatever their route bits hold. Once the tail is granted and the channel FIFO is empty, `out_req` returns to zero.
- R6: Each channel buffers up to 4 flits. `up_ready[v]` is zero while channel v holds 4 flits and returns to one after a pop. A flit sent to a full channel is discarded.
- R7: Flits of one channel leave in the order they arrived.
- R8: Several channels can hold outputs at once. When more than one channel has a flit ready, the lowest-numbered channel is offered first. `out_req` is always zero or one-hot.
- R9: A packet with a routing error is dropped up to and including its tail, and it never raises a request. `route_err` is high for one cycle, one cycle after the bad head reaches the front of its FIFO.
- R10: A head flit sampled at rising edge k is offered at `out_req` after rising edge k+1 and not before.
- R11: While `out_req` is nonzero and `out_gnt` is low, the offered flit, channel and request stay stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_kind | input | 2 | Incoming flit kind: 00 idle, 01 head, 10 body, 11 tail |
| in_vc | input | 3 | Virtual channel of the incoming flit |
| in_route | input | 16 | Source route, lowest two bits are this hop |
| in_data | input | 32 | Flit payload |
| up_ready | output | 8 | Per-channel ready to the sender, low when that FIFO is full |
| out_req | output | 5 | One-hot request to output N, E, S, W, local (bits 0..4) |
| out_gnt | input | 1 | Grant for the current request; the flit leaves on this edge |
| out_kind | output | 2 | Kind of the offered flit, idle when no request |
| out_vc | output | 3 | Channel of the offered flit |
| out_route | output | 16 | Route of the offered flit, shifted on head flits |
| out_data | output | 32 | Payload of the offered flit |
| route_err | output | 1 | One-cycle pulse when a head flit has an illegal turn |

## Verification
A corrupted channel state shows up at the ports within a few cycles. A channel stuck in its active state would keep requesting after its tail had left. A channel stuck in drop would swallow the next good packet on that channel, and `out_req` would stay zero two edges after the head where a request is expected. A wrong hold register would move the request when a body flit's own route bits point elsewhere, so the bench gives body and tail flits route bits that decode to a different output. A miscounted FIFO would show a wrong `up_ready` pattern, or let a flit sent to a full channel reappear after the drain.

// File: rtl/srin_pkg.sv
`timescale 1ns/1ps
package srin_pkg;

    localparam int NUM_VC     = 8;
    localparam int VC_W       = $clog2(NUM_VC);
    localparam int ROUTE_W    = 16;
    localparam int HOP_W      = 2;
    localparam int DATA_W     = 32;
    localparam int NUM_DIR    = 5;
    localparam int DIR_W      = $clog2(NUM_DIR);
    localparam int LOCAL_PORT = NUM_DIR - 1;

    typedef enum logic [1:0] {
        FK_IDLE = 2'b00,
        FK_HEAD = 2'b01,
        FK_BODY = 2'b10,
        FK_TAIL = 2'b11
    } flit_kind_e;

    typedef enum logic [1:0] {
        HOP_STRAIGHT = 2'b00,
        HOP_LEFT     = 2'b01,
        HOP_RIGHT    = 2'b10,
        HOP_EXTRACT  = 2'b11
    } hop_e;

    typedef enum logic [1:0] {
        VS_IDLE,
        VS_ACTIVE,
        VS_DROP
    } vc_state_e;

    typedef struct packed {
        flit_kind_e           kind;
        logic [ROUTE_W-1:0]   route;
        logic [DATA_W-1:0]    data;
    } flit_t;

    // Route as seen by the next router: this hop consumed, zero-filled on top.
    function automatic logic [ROUTE_W-1:0] next_route(input logic [ROUTE_W-1:0] r);
        return r >> HOP_W;
    endfunction

endpackage

// File: rtl/srin_vc_fifo.sv
`timescale 1ns/1ps
module srin_vc_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/srin_hop_decode.sv
`timescale 1ns/1ps
module srin_hop_decode
    import srin_pkg::*;
#(
    parameter int PORT_ID    = 0,
    parameter int LOCAL_HEAD = 0
) (
    input  logic [HOP_W-1:0] hop,
    output logic [DIR_W-1:0] dir,
    output logic             bad
);
    localparam bit       IS_LOCAL = (PORT_ID == LOCAL_PORT);
    localparam int       HEAD_I   = IS_LOCAL ? LOCAL_HEAD : ((PORT_ID + 2) % 4);
    localparam logic [1:0] HEADING = HEAD_I[1:0];

    logic [1:0] turned;

    always_comb begin
        bad    = 1'b0;
        turned = HEADING;
        dir    = DIR_W'(LOCAL_PORT);
        case (hop)
            HOP_STRAIGHT: begin
                turned = HEADING;
                dir    = {1'b0, turned};
                bad    = IS_LOCAL;
            end
            HOP_LEFT: begin
                turned = HEADING + 2'd3;
                dir    = {1'b0, turned};
            end
            HOP_RIGHT: begin
                turned = HEADING + 2'd1;
                dir    = {1'b0, turned};
            end
            default: begin
                dir = DIR_W'(LOCAL_PORT);
            end
        endcase
    end
endmodule

// File: rtl/srin_vc_pick.sv
`timescale 1ns/1ps
module srin_vc_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    input  logic          lock_vld,
    input  logic [IW-1:0] lock_idx,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |elig;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                idx = IW'(i);
            end
        end
        if (lock_vld && elig[lock_idx]) begin
            idx = lock_idx;
        end
    end
endmodule

// File: rtl/srcroute_in_ctrl.sv
`timescale 1ns/1ps
module srcroute_in_ctrl
    import srin_pkg::*;
#(
    parameter int PORT_ID    = 0,
    parameter int LOCAL_HEAD = 0,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          in_kind,
    input  logic [VC_W-1:0]     in_vc,
    input  logic [ROUTE_W-1:0]  in_route,
    input  logic [DATA_W-1:0]   in_data,
    output logic [NUM_VC-1:0]   up_ready,
    output logic [NUM_DIR-1:0]  out_req,
    input  logic                out_gnt,
    output logic [1:0]          out_kind,
    output logic [VC_W-1:0]     out_vc,
    output logic [ROUTE_W-1:0]  out_route,
    output logic [DATA_W-1:0]   out_data,
    output logic                route_err
);
    localparam int FLIT_W = $bits(flit_t);

    flit_t              wr_flit;
    logic [NUM_VC-1:0]  push, pop, empty, full;
    logic [FLIT_W-1:0]  q_raw   [NUM_VC];
    flit_kind_e         hkind   [NUM_VC];
    logic [ROUTE_W-1:0] hroute  [NUM_VC];
    logic [DATA_W-1:0]  hdata   [NUM_VC];
    logic [DIR_W-1:0]   dec_dir [NUM_VC];
    logic [NUM_VC-1:0]  dec_bad;

    vc_state_e          vst     [NUM_VC];
    logic [DIR_W-1:0]   vdir    [NUM_VC];

    logic [NUM_VC-1:0]  start_ok, start_bad, discard, elig;
    logic               sel_any, fire;
    logic [VC_W-1:0]    sel_idx;
    logic               lock_vld;
    logic [VC_W-1:0]    lock_idx;

    assign wr_flit = '{kind: flit_kind_e'(in_kind), route: in_route, data: in_data};

    // Per-channel storage and turn decode at the front of each FIFO.
    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
            flit_t hf;

            srin_vc_fifo #(
                .WIDTH (FLIT_W),
                .DEPTH (FIFO_DEPTH)
            ) u_fifo (
                .clk   (clk),
                .rst   (rst),
                .push  (push[v]),
                .din   (wr_flit),
                .pop   (pop[v]),
                .dout  (q_raw[v]),
                .empty (empty[v]),
                .full  (full[v])
            );

            assign hf        = flit_t'(q_raw[v]);
            assign hkind[v]  = hf.kind;
            assign hroute[v] = hf.route;
            assign hdata[v]  = hf.data;

            srin_hop_decode #(
                .PORT_ID    (PORT_ID),
                .LOCAL_HEAD (LOCAL_HEAD)
            ) u_dec (
                .hop (hf.route[HOP_W-1:0]),
                .dir (dec_dir[v]),
                .bad (dec_bad[v])
            );
        end
    endgenerate

    srin_vc_pick #(
        .N  (NUM_VC),
        .IW (VC_W)
    ) u_pick (
        .elig     (elig),
        .lock_vld (lock_vld),
        .lock_idx (lock_idx),
        .any      (sel_any),
        .idx      (sel_idx)
    );

    assign fire = sel_any && out_gnt;

    always_comb begin
        for (int v = 0; v < NUM_VC; v++) begin
            push[v]      = (in_kind != FK_IDLE) && (in_vc == VC_W'(v));
            up_ready[v]  = !full[v];
            start_ok[v]  = (vst[v] == VS_IDLE) && !empty[v] &&
                           (hkind[v] == FK_HEAD) && !dec_bad[v];
            start_bad[v] = (vst[v] == VS_IDLE) && !empty[v] &&
                           (hkind[v] == FK_HEAD) && dec_bad[v];
            // Drop mode flushes the bad packet; stray non-head flits on an
            // idle channel have no output and are flushed as well.
            discard[v]   = !empty[v] &&
                           ((vst[v] == VS_DROP) ||
                            ((vst[v] == VS_IDLE) && ((hkind[v] != FK_HEAD) || dec_bad[v])));
            elig[v]      = (vst[v] == VS_ACTIVE) && !empty[v];
            pop[v]       = discard[v] || (fire && (sel_idx == VC_W'(v)));
        end
    end

    always_comb begin
        out_req   = '0;
        out_kind  = FK_IDLE;
        out_vc    = '0;
        out_route = '0;
        out_data  = '0;
        if (sel_any) begin
            out_req[vdir[sel_idx]] = 1'b1;
            out_kind  = hkind[sel_idx];
            out_vc    = sel_idx;
            out_data  = hdata[sel_idx];
            out_route = (hkind[sel_idx] == FK_HEAD) ? next_route(hroute[sel_idx])
                                                    : hroute[sel_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int v = 0; v < NUM_VC; v++) begin
                vst[v]  <= VS_IDLE;
                vdir[v] <= '0;
            end
            route_err <= 1'b0;
            lock_vld  <= 1'b0;
            lock_idx  <= '0;
        end else begin
            for (int v = 0; v < NUM_VC; v++) begin
                case (vst[v])
                    VS_IDLE: begin
                        if (start_ok[v]) begin
                            vst[v]  <= VS_ACTIVE;
                            vdir[v] <= dec_dir[v];
                        end else if (start_bad[v]) begin
                            vst[v] <= VS_DROP;
                        end
                    end
                    VS_ACTIVE: begin
                        if (fire && (sel_idx == VC_W'(v)) && (hkind[v] == FK_TAIL)) begin
                            vst[v] <= VS_IDLE;
                        end
                    end
                    VS_DROP: begin
                        if (!empty[v] && (hkind[v] == FK_TAIL)) begin
                            vst[v] <= VS_IDLE;
                        end
                    end
                    default: vst[v] <= VS_IDLE;
                endcase
            end
            route_err <= |start_bad;
            lock_vld  <= sel_any && !out_gnt;
            lock_idx  <= sel_idx;
        end
    end
endmodule

// File: rtl/srcroute_in_ctrl_chk.sv
`timescale 1ns/1ps
module srcroute_in_ctrl_chk
    import srin_pkg::*;
#(
    parameter int PORT_ID    = 0,
    parameter int LOCAL_HEAD = 0
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_VC-1:0]  up_ready,
    input logic [NUM_DIR-1:0] out_req,
    input logic               out_gnt,
    input logic [1:0]         out_kind,
    input logic [VC_W-1:0]    out_vc,
    input logic [ROUTE_W-1:0] out_route,
    input logic [DATA_W-1:0]  out_data
);
    localparam int BACK = (PORT_ID == LOCAL_PORT) ? LOCAL_HEAD : PORT_ID;

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_req)); // R8

    AST_NO_BACK_TURN: assert property (@(posedge clk) disable iff (rst)
        out_req[BACK] == 1'b0); // R2 R3

    AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (rst)
        ((|out_req) && !out_gnt) |=>
            ($stable(out_req) && $stable(out_vc) && $stable(out_kind) &&
             $stable(out_data) && $stable(out_route))); // R11

    AST_READY_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
        ((|out_req) && out_gnt) |=> up_ready[$past(out_vc)]); // R6

    AST_HEAD_ROUTE_FILL: assert property (@(posedge clk) disable iff (rst)
        ((|out_req) && (out_kind == 2'b01)) |-> (out_route[ROUTE_W-1 -: HOP_W] == '0)); // R4
endmodule

bind srcroute_in_ctrl srcroute_in_ctrl_chk #(
    .PORT_ID    (PORT_ID),
    .LOCAL_HEAD (LOCAL_HEAD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .up_ready  (up_ready),
    .out_req   (out_req),
    .out_gnt   (out_gnt),
    .out_kind  (out_kind),
    .out_vc    (out_vc),
    .out_route (out_route),
    .out_data  (out_data)
);

// File: tb/srcroute_in_ctrl_test.sv
`timescale 1ns/1ps
module srcroute_in_ctrl_test;
    import srin_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk; // 20 ns period, 50 MHz

    int checks   = 0;
    int failures = 0;
    bit loc_sel  = 1'b0;

    logic [1:0]  n_kind = 2'b00, l_kind = 2'b00;
    logic [2:0]  n_vc = '0, l_vc = '0;
    logic [15:0] n_route = '0, l_route = '0;
    logic [31:0] n_data = '0, l_data = '0;
    logic        n_gnt = 1'b0, l_gnt = 1'b0;
    logic [7:0]  n_ready, l_ready;
    logic [4:0]  n_req, l_req;
    logic [1:0]  n_okind, l_okind;
    logic [2:0]  n_ovc, l_ovc;
    logic [15:0] n_oroute, l_oroute;
    logic [31:0] n_odata, l_odata;
    logic        n_err, l_err;

    srcroute_in_ctrl #(.PORT_ID(0), .LOCAL_HEAD(0), .FIFO_DEPTH(4)) uut (
        .clk(clk), .rst(rst), .in_kind(n_kind), .in_vc(n_vc), .in_route(n_route),
        .in_data(n_data), .up_ready(n_ready), .out_req(n_req), .out_gnt(n_gnt),
        .out_kind(n_okind), .out_vc(n_ovc), .out_route(n_oroute), .out_data(n_odata),
        .route_err(n_err));

    srcroute_in_ctrl #(.PORT_ID(4), .LOCAL_HEAD(0), .FIFO_DEPTH(4)) uut_local (
        .clk(clk), .rst(rst), .in_kind(l_kind), .in_vc(l_vc), .in_route(l_route),
        .in_data(l_data), .up_ready(l_ready), .out_req(l_req), .out_gnt(l_gnt),
        .out_kind(l_okind), .out_vc(l_ovc), .out_route(l_oroute), .out_data(l_odata),
        .route_err(l_err));

    logic [4:0]  m_req;
    logic [1:0]  m_kind;
    logic [2:0]  m_vc;
    logic [15:0] m_route;
    logic [31:0] m_data;
    logic        m_err;
    assign m_req   = loc_sel ? l_req    : n_req;
    assign m_kind  = loc_sel ? l_okind  : n_okind;
    assign m_vc    = loc_sel ? l_ovc    : n_ovc;
    assign m_route = loc_sel ? l_oroute : n_oroute;
    assign m_data  = loc_sel ? l_odata  : n_odata;
    assign m_err   = loc_sel ? l_err    : n_err;

    // {local, vc, route, expected one-hot request, expected forwarded route}
    localparam int NVEC = 9;
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 16'h1230, 5'b00100, 16'h048C},
        {1'b0, 3'd1, 16'h1231, 5'b00010, 16'h048C},
        {1'b0, 3'd7, 16'h1232, 5'b01000, 16'h048C},
        {1'b0, 3'd3, 16'h1233, 5'b10000, 16'h048C},
        {1'b0, 3'd4, 16'hFFFD, 5'b00010, 16'h3FFF},
        {1'b0, 3'd6, 16'h8002, 5'b01000, 16'h2000},
        {1'b1, 3'd1, 16'h00F1, 5'b01000, 16'h003C},
        {1'b1, 3'd6, 16'h00F2, 5'b00010, 16'h003C},
        {1'b1, 3'd0, 16'h00F3, 5'b10000, 16'h003C}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] k, input logic [2:0] vc,
                         input logic [15:0] r, input logic [31:0] d);
        if (loc_sel) begin
            l_kind = k; l_vc = vc; l_route = r; l_data = d;
        end else begin
            n_kind = k; n_vc = vc; n_route = r; n_data = d;
        end
    endtask

    task automatic grant(input logic g);
        if (loc_sel) l_gnt = g;
        else         n_gnt = g;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check("R1", "north req", 64'(n_req), 64'h0);
        check("R1", "north ready", 64'(n_ready), 64'hFF);
        check("R1", "north err", 64'(n_err), 64'h0);
        check("R1", "north kind", 64'(n_okind), 64'h0);
        check("R1", "local ready", 64'(l_ready), 64'hFF);
        check("R1", "local req", 64'(l_req), 64'h0);

        // R9 straight code on the local input: whole packet dropped
        loc_sel = 1'b1;
        @(negedge clk) drive(2'b01, 3'd1, 16'h0F30, 32'h500);
        @(negedge clk) drive(2'b10, 3'd1, 16'h0F33, 32'h501);
        @(negedge clk) drive(2'b11, 3'd1, 16'h0F33, 32'h502);
        check("R9", "err pulse", 64'(m_err), 64'h1);
        check("R9", "no req on error", 64'(m_req), 64'h0);
        @(negedge clk) drive(2'b00, 3'd0, 16'h0, 32'h0);
        check("R9", "err single cycle", 64'(m_err), 64'h0);
        check("R9", "body dropped", 64'(m_req), 64'h0);
        @(negedge clk);
        check("R9", "tail dropped", 64'(m_req), 64'h0);
        @(negedge clk);
        check("R9", "still no req", 64'(m_req), 64'h0);

        // Vector walk: decode, shift, hold, latency
        for (int i = 0; i < NVEC; i++) begin
            logic [40:0] e;
            string dreq;
            e = VEC[i];
            loc_sel = e[40];
            dreq = e[40] ? "R3" : "R2";
            @(negedge clk) drive(2'b01, e[39:37], e[36:21], 32'hD000_0000 + 32'(i));
            @(negedge clk) drive(2'b11, e[39:37], 16'hBEEF, 32'hE000_0000 + 32'(i));
            check("R10", "no req one edge after head", 64'(m_req), 64'h0);
            @(negedge clk) drive(2'b00, 3'd0, 16'h0, 32'h0);
            check(dreq, "decoded req", 64'(m_req), 64'(e[20:16]));
            check("R4", "head route shifted", 64'(m_route), 64'(e[15:0]));
            check("R10", "head kind", 64'(m_kind), 64'h1);
            check("R10", "head vc/data", {29'h0, m_vc, m_data},
                  {29'h0, e[39:37], 32'hD000_0000 + 32'(i)});
            grant(1'b1);
            @(negedge clk);
            check("R5", "tail held on same output", 64'(m_req), 64'(e[20:16]));
            check("R4", "tail route unchanged", 64'(m_route), 64'hBEEF);
            check("R7", "tail kind/data", {30'h0, m_kind, m_data},
                  {30'h0, 2'b11, 32'hE000_0000 + 32'(i)});
            @(negedge clk) grant(1'b0);
            check("R5", "req released after tail", 64'(m_req), 64'h0);
        end

        // R6 full channel: fifth flit discarded, ready low while full
        loc_sel = 1'b0;
        @(negedge clk) drive(2'b01, 3'd3, 16'h0011, 32'h300);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk) drive(2'b10, 3'd3, 16'h0003, 32'h300 + 32'(k));
        end
        @(negedge clk) drive(2'b11, 3'd3, 16'h0, 32'h304);
        check("R6", "ready low when full", 64'(n_ready), 64'hF7);
        @(negedge clk) drive(2'b00, 3'd0, 16'h0, 32'h0);
        check("R6", "ready still low", 64'(n_ready), 64'hF7);
        check("R11", "head waiting for grant", {27'h0, n_req, n_odata}, {27'h0, 5'b00010, 32'h300});
        grant(1'b1);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check("R7", "body order", {30'h0, n_okind, n_odata}, {30'h0, 2'b10, 32'h300 + 32'(k)});
            check("R5", "body held on head output", 64'(n_req), 64'h02);
        end
        check("R6", "ready back after pop", 64'(n_ready), 64'hFF);
        @(negedge clk) grant(1'b0);
        check("R6", "tail sent to full fifo discarded", 64'(n_req), 64'h0);
        drive(2'b11, 3'd3, 16'h0, 32'h305);
        @(negedge clk) drive(2'b00, 3'd0, 16'h0, 32'h0);
        check("R5", "late tail on held output", {27'h0, n_req, n_odata}, {27'h0, 5'b00010, 32'h305});
        grant(1'b1);
        @(negedge clk) grant(1'b0);
        check("R5", "released after late tail", 64'(n_req), 64'h0);

        // R8 two channels holding outputs at once, lower channel first
        @(negedge clk) drive(2'b01, 3'd5, 16'h0002, 32'h50);
        @(negedge clk) drive(2'b01, 3'd2, 16'h0001, 32'h20);
        @(negedge clk) drive(2'b11, 3'd5, 16'h0000, 32'h51);
        check("R8", "vc5 head first", {24'h0, n_req, n_ovc, n_odata}, {24'h0, 5'b01000, 3'd5, 32'h50});
        grant(1'b1);
        @(negedge clk) drive(2'b11, 3'd2, 16'h0000, 32'h21);
        check("R8", "vc2 head", {24'h0, n_req, n_ovc, n_odata}, {24'h0, 5'b00010, 3'd2, 32'h20});
        @(negedge clk) drive(2'b00, 3'd0, 16'h0, 32'h0);
        check("R8", "lower vc preferred", {24'h0, n_req, n_ovc, n_odata}, {24'h0, 5'b00010, 3'd2, 32'h21});
        @(negedge clk);
        check("R8", "vc5 still holds west", {24'h0, n_req, n_ovc, n_odata}, {24'h0, 5'b01000, 3'd5, 32'h51});
        @(negedge clk) grant(1'b0);
        check("R8", "all released", 64'(n_req), 64'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule